// File: doc/BRIEF.md
# Two-Pass Message Cache Feeder

This block sits between an upstream byte stream with a valid/ready handshake and the byte input of a hash engine. It is used when a message is hashed twice, as in signature generation. On the capture pass it forwards every incoming byte downstream and stores the leading bytes in a local on-chip byte buffer. On the replay pass it serves those stored bytes from the buffer and only fetches bytes past the buffered region from upstream. A single-pass mode covers verification: bytes are forwarded once and the buffer is left untouched.

Each pass starts with a command pulse that carries the mode and the message length in bytes. The feeder counts accepted bytes and ends the pass when the count reaches that length. If the stream marks its end too early, the feeder ends the pass with an error. While a pass runs, the feeder shows a request flag and the current byte offset, so the transport knows which bytes it must supply.

Top module: `msg_feeder`

## Requirements
- R1: After reset, `busy`, `dn_valid`, `up_ready`, `up_req`, `done` and `frame_err` are all low.
- R2: In capture mode (`cmd_mode` = 0) and single mode (`cmd_mode` = 2 or 3), each upstream byte appears unchanged and in order on `dn_data`. `up_ready` is never high while `dn_ready` is low.
- R3: A capture pass writes message offsets below `BUF_BYTES` into the buffer. In a replay pass (`cmd_mode` = 1), those offsets are delivered from the buffer, and `up_ready` and `up_req` stay low while they are delivered.
- R4: In a replay pass, offsets at or above `BUF_BYTES` are taken from upstream. `up_req` is high and `up_offset` equals the offset of the next byte to be delivered.
- R5: For an N-byte message, the number of upstream handshakes over one capture pass plus one replay pass is N + max(N - `BUF_BYTES`, 0).
- R6: A single-mode pass takes exactly N upstream bytes and does not change the buffer contents.
- R7: In a replay pass, `dn_valid` is low in the first cycle after the start command and high in the second cycle, one cycle after the first buffer read.
- R8: `dn_last` marks the byte at offset N-1. `done` is a one-cycle pulse in the cycle after that byte is accepted, and `busy` is then low. A command with N = 0 produces `done` in the next cycle and delivers no bytes.
- R9: If an upstream byte at an offset below N-1 is accepted with `up_last` high, the pass ends after that byte. `done` and `frame_err` then pulse together.
- R10: `cmd_start` is ignored while `busy` is high, so a running pass keeps its length and mode.
- R11: While a buffered byte is stalled (`dn_valid` high, `dn_ready` low), `dn_valid` and `dn_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pass start pulse, taken only when idle |
| cmd_mode | input | 2 | 0 capture, 1 replay, 2 or 3 single |
| cmd_len | input | LEN_W | Message length in bytes |
| up_valid | input | 1 | Upstream byte valid |
| up_ready | output | 1 | Upstream byte accepted when high with up_valid |
| up_data | input | 8 | Upstream byte |
| up_last | input | 1 | Upstream marks its final byte |
| up_req | output | 1 | Feeder needs upstream bytes |
| up_offset | output | LEN_W | Message offset of the next byte |
| dn_valid | output | 1 | Downstream byte valid |
| dn_ready | input | 1 | Downstream consumer ready |
| dn_data | output | 8 | Downstream byte |
| dn_last | output | 1 | Downstream byte is offset N-1 |
| busy | output | 1 | A pass is running |
| done | output | 1 | One-cycle pass completion pulse |
| frame_err | output | 1 | Pulses with done when the stream ended early |

## Verification
Every message length from zero to well past the buffer size is run through a capture pass and then a replay pass. This tells apart messages that fit inside the buffer, fill it exactly, or overflow it, and it checks the upstream byte total for each case. Downstream stalls and upstream gaps follow different periodic patterns, so stall propagation and the hold of buffered data are exercised at many phases. A single-mode pass with different data between a capture pass and a replay pass shows whether the buffer was left alone. Early end markers, both in the forwarded region and in the replay overflow region, and a start command given mid-pass cover the error and lockout paths.

// File: rtl/msg_feeder_pkg.sv
package msg_feeder_pkg;
  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_REPLAY  = 2'd1,
    MODE_SINGLE  = 2'd2
  } feed_mode_e;

  function automatic feed_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd0:    return MODE_CAPTURE;
      2'd1:    return MODE_REPLAY;
      default: return MODE_SINGLE;
    endcase
  endfunction
endpackage

// File: rtl/msg_feeder_ram.sv
module msg_feeder_ram #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  // storage array is not reset; read port has one cycle of latency
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/msg_feeder_seq.sv
module msg_feeder_seq
  import msg_feeder_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_mode,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             up_valid,
  input  logic             up_last,
  input  logic             dn_ready,
  output logic             busy,
  output logic             src_buf,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_vld,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [LEN_W-1:0] cnt,
  output logic             last_pos,
  output logic             done,
  output logic             frame_err
);
  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

  logic             busy_q, busy_n;
  feed_mode_e       mode_q, mode_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] raddr_q, raddr_n;
  logic             rvld_q, rvld_n;
  logic             done_q, done_n;
  logic             ferr_q, ferr_n;

  logic [LEN_W-1:0] rd_limit;
  logic [LEN_W-1:0] cnt_inc;
  logic             dn_acc, up_acc, load_cmd;

  always_comb begin
    src_buf  = busy_q && (mode_q == MODE_REPLAY) && (cnt_q < BUF_LEN);
    rd_limit = (len_q < BUF_LEN) ? len_q : BUF_LEN;
    rd_en    = src_buf && (raddr_q < rd_limit) && (!rvld_q || dn_ready);
    dn_acc   = busy_q && dn_ready && (src_buf ? rvld_q : up_valid);
    up_acc   = dn_acc && !src_buf;
    cnt_inc  = cnt_q + LEN_W'(1);
    wr_en    = up_acc && (mode_q == MODE_CAPTURE) && (cnt_q < BUF_LEN);
    load_cmd = !busy_q && cmd_start && (cmd_len != '0);
  end

  // next-state process
  always_comb begin
    busy_n  = busy_q;
    mode_n  = mode_q;
    len_n   = len_q;
    cnt_n   = cnt_q;
    raddr_n = raddr_q;
    rvld_n  = rvld_q;
    done_n  = 1'b0;
    ferr_n  = 1'b0;
    if (!busy_q) begin
      if (cmd_start && (cmd_len == '0)) begin
        done_n = 1'b1;
      end else if (load_cmd) begin
        busy_n  = 1'b1;
        mode_n  = decode_mode(cmd_mode);
        len_n   = cmd_len;
        cnt_n   = '0;
        raddr_n = '0;
        rvld_n  = 1'b0;
      end
    end else begin
      if (rd_en) begin
        raddr_n = raddr_q + LEN_W'(1);
        rvld_n  = 1'b1;
      end else if (dn_acc && src_buf) begin
        rvld_n  = 1'b0;
      end
      if (dn_acc) begin
        cnt_n = cnt_inc;
        if (cnt_inc == len_q) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else if (up_acc && up_last) begin
          busy_n = 1'b0;
          done_n = 1'b1;
          ferr_n = 1'b1;
        end
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_CAPTURE;
      len_q   <= '0;
      cnt_q   <= '0;
      raddr_q <= '0;
      rvld_q  <= 1'b0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      ferr_q <= ferr_n;
      rvld_q <= rvld_n;
      if (load_cmd) begin
        mode_q <= mode_n;
        len_q  <= len_n;
      end
      if (load_cmd || dn_acc) cnt_q <= cnt_n;
      if (load_cmd || rd_en) raddr_q <= raddr_n;
    end
  end

  assign busy      = busy_q;
  assign rd_vld    = rvld_q;
  assign rd_addr   = raddr_q[AW-1:0];
  assign wr_addr   = cnt_q[AW-1:0];
  assign cnt       = cnt_q;
  assign last_pos  = (cnt_inc == len_q);
  assign done      = done_q;
  assign frame_err = ferr_q;
endmodule

// File: rtl/msg_feeder.sv
module msg_feeder #(
  parameter int BUF_BYTES = 4096,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_mode,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [7:0]       up_data,
  input  logic             up_last,
  output logic             up_req,
  output logic [LEN_W-1:0] up_offset,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [7:0]       dn_data,
  output logic             dn_last,
  output logic             busy,
  output logic             done,
  output logic             frame_err
);
  logic          src_buf, rd_en, rd_vld, wr_en, last_pos;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    ram_q;

  msg_feeder_seq #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_mode(cmd_mode), .cmd_len(cmd_len),
    .up_valid(up_valid), .up_last(up_last), .dn_ready(dn_ready),
    .busy(busy), .src_buf(src_buf),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .cnt(up_offset), .last_pos(last_pos),
    .done(done), .frame_err(frame_err)
  );

  msg_feeder_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk(clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(up_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(ram_q)
  );

  assign up_req   = busy && !src_buf;
  assign up_ready = up_req && dn_ready;
  assign dn_valid = src_buf ? rd_vld : (busy && up_valid);
  assign dn_data  = src_buf ? ram_q : up_data;
  assign dn_last  = dn_valid && last_pos;
endmodule

// File: rtl/msg_feeder_chk.sv
module msg_feeder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       frame_err,
  input logic       src_buf,
  input logic       dn_valid,
  input logic       dn_ready,
  input logic [7:0] dn_data
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_FERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> done); // R9
  AST_REPLAY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && src_buf) |-> !dn_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_buf && dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R11
endmodule

bind msg_feeder msg_feeder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .frame_err(frame_err),
  .src_buf(src_buf), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
);

// File: tb/msg_feeder_test.sv
module msg_feeder_test;
  localparam int BUF = 16;
  localparam int LW = 8;

  logic          clk, rst_n, cmd_start;
  logic [1:0]    cmd_mode;
  logic [LW-1:0] cmd_len, up_offset;
  logic          up_valid, up_ready, up_last, up_req;
  logic [7:0]    up_data, dn_data;
  logic          dn_valid, dn_ready, dn_last, busy, done, frame_err;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  msg_feeder #(.BUF_BYTES(BUF), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
    .cmd_len(cmd_len), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_last(up_last), .up_req(up_req),
    .up_offset(up_offset), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_data(dn_data), .dn_last(dn_last), .busy(busy), .done(done),
    .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 13 + 7) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode: 0 capture, 1 replay, 2 single. early: offset carrying a premature end mark, -1 none.
  task automatic run_pass(input int mode, input int n, input int seed, input int bseed,
                          input int early, input bit poke, output int ups);
    int src, got, exp_got;
    bit fin, ferr, bad_up, bad_off, bad_stall, bad_data, bad_last;
    logic [7:0] expd;
    src = (mode == 1) ? ((n > BUF) ? BUF : n) : 0;
    got = 0; ups = 0; fin = 0; ferr = 0;
    bad_up = 0; bad_off = 0; bad_stall = 0; bad_data = 0; bad_last = 0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_mode = 2'(mode); cmd_len = LW'(n);
    up_valid = 1'b0; up_last = 1'b0; dn_ready = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 3000 && !fin; c++) begin
      @(negedge clk);
      cmd_start = poke && (c == 3);
      cmd_len   = poke ? LW'(n + 9) : LW'(n);
      if (poke) cmd_mode = 2'd0;
      dn_ready  = (c % 5) != 3;
      up_valid  = ((c % 7) != 2) && (src < n);
      up_data   = pat(seed, src);
      up_last   = (src == n - 1) || (src == early);
      #3;
      if (mode == 1 && n > 0 && c == 0) chk(!dn_valid, "R7 no valid first cycle", int'(dn_valid), 0);
      if (mode == 1 && n > 0 && c == 1) chk(dn_valid, "R7 valid second cycle", int'(dn_valid), 1);
      if (done) begin
        fin = 1; ferr = frame_err;
      end else begin
        if (mode == 1 && got < BUF && (up_ready || up_req)) bad_up = 1;
        if (up_req && up_offset != LW'(got)) bad_off = 1;
        if (up_ready && !dn_ready) bad_stall = 1;
        if (up_valid && up_ready) begin src++; ups++; end
        if (dn_valid && dn_ready) begin
          expd = (mode == 1 && got < BUF) ? pat(bseed, got) : pat(seed, got);
          if (dn_data !== expd) begin
            if (!bad_data) chk(0, "R2/R3 data", int'(dn_data), int'(expd));
            bad_data = 1;
          end
          if (dn_last !== (got == n - 1)) bad_last = 1;
          got++;
        end
      end
    end
    cmd_start = 1'b0; up_valid = 1'b0; up_last = 1'b0;
    exp_got = (early >= 0) ? early + 1 : n;
    chk(fin, "R8 done seen", int'(fin), 1);
    chk(got == exp_got, "R8 byte count", got, exp_got);
    chk(!bad_data, "R2 byte stream", int'(bad_data), 0);
    chk(!bad_last, "R8 last marker", int'(bad_last), 0);
    chk(ferr == (early >= 0), "R9 frame error", int'(ferr), int'(early >= 0));
    chk(!bad_stall, "R2 stall propagation", int'(bad_stall), 0);
    if (mode == 1) chk(!bad_up, "R3 no upstream in buffered region", int'(bad_up), 0);
    chk(!bad_off, "R4 offset", int'(bad_off), 0);
    @(negedge clk); #3;
    chk(!done && !busy, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    int u1, u2, ex;
    rst_n = 1'b0; cmd_start = 1'b0; cmd_mode = 2'd0; cmd_len = '0;
    up_valid = 1'b0; up_data = '0; up_last = 1'b0; dn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    chk(!busy && !dn_valid && !up_ready && !up_req && !done && !frame_err,
        "R1 reset state", int'({busy, dn_valid, up_ready, up_req, done, frame_err}), 0);
    rst_n = 1'b1;

    // capture then replay for every length around the buffer size (R3, R4, R5)
    for (int n = 0; n <= 2 * BUF + 8; n++) begin
      run_pass(0, n, n, 0, -1, 0, u1);
      run_pass(1, n, n, n, -1, 0, u2);
      ex = n + ((n > BUF) ? n - BUF : 0);
      chk(u1 + u2 == ex, "R5 upstream total", u1 + u2, ex);
    end

    // single pass leaves the buffer alone (R6)
    run_pass(0, 20, 100, 0, -1, 0, u1);
    run_pass(2, 12, 200, 0, -1, 0, u1);
    chk(u1 == 12, "R6 single pass upstream count", u1, 12);
    run_pass(1, 20, 100, 100, -1, 0, u1);
    chk(u1 == 4, "R6 replay after single pass", u1, 4);

    // premature end marks (R9)
    run_pass(0, 10, 3, 0, 5, 0, u1);
    run_pass(0, 30, 50, 0, -1, 0, u1);
    run_pass(1, 30, 50, 50, 20, 0, u1);

    // start while busy is ignored (R10)
    run_pass(2, 25, 77, 0, -1, 1, u1);
    chk(u1 == 25, "R10 start ignored while busy", u1, 25);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule